// File: doc/BRIEF.md
# Receive Descriptor Ring Poller

This block walks a ring of receive buffer descriptors kept in memory on behalf of an Ethernet-style receive engine. Software fills descriptors, marks each free buffer as empty, and then strobes a command register. From then on, as long as the global enable is high, the poller reads descriptors one after another. It offers each empty buffer's pointer to the frame datapath. When a frame finishes, it writes the received length back into the descriptor.

Each descriptor takes eight bytes. The first word is the control word: bit 15 is the empty flag, bit 13 is the wrap flag, and bits 31:16 hold the length. The second word is the buffer pointer. When the poller reads a control word whose empty flag is clear, software has not handed that buffer over. The poller then disarms itself and stays parked on that descriptor. It starts again only after the next command strobe. The command strobe carries no data, because any write arms the poller.

Top module: `rx_ring_poller`

## Requirements
- R1: A one-cycle pulse on `cmd_wr` makes `active` read 1 from the next cycle on, whatever state the poller is in.
- R2: No descriptor memory access starts unless `active` and `eth_en` were both high in the cycle before.
- R3: For a descriptor, the poller reads the control word at the ring index and then the pointer word at index+4. If control bit 15 (empty) is set, it raises `buf_valid` with `buf_ptr` equal to the pointer word. It holds both until `frame_done`.
- R4: If a control word is read with bit 15 clear, `active` drops and no further access occurs until the next `cmd_wr`. The next poll restarts at that same descriptor.
- R5: On `frame_done`, the poller makes one write to the control word's address. The written value has bits 31:16 = `frame_len`, bit 15 = 0, and bits 14:0 unchanged. `rx_evt` pulses for exactly one cycle, in the cycle after that write is acknowledged.
- R6: After a write-back, the ring index moves on by 8 bytes. If control bit 13 (wrap) was set, it returns to `RING_BASE` instead.
- R7: After reset, `active`, `mem_req` and `buf_valid` are 0, and the first fetch is at `RING_BASE`.
- R8: If `cmd_wr` arrives in the same cycle as the self-clear of R4, `active` stays 1.
- R9: When `eth_en` drops, a memory access that has already started is held until it is acknowledged. After that, no new access starts, a buffer offer is withdrawn, and the next fetch after re-enable is at `RING_BASE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe; arms polling |
| eth_en | input | 1 | Global receive enable |
| mem_req | output | 1 | Descriptor memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the descriptor word |
| mem_wdata | output | 32 | Write data (control word write-back) |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| buf_valid | output | 1 | Empty buffer offered to the frame datapath |
| buf_ptr | output | 32 | Buffer pointer of the offered descriptor |
| frame_done | input | 1 | Datapath finished a frame into the offered buffer |
| frame_len | input | 16 | Received frame length, valid with `frame_done` |
| rx_evt | output | 1 | One-cycle frame-received event |
| active | output | 1 | Polling armed |

## Verification
Three frames are run through a ring of four descriptors, each with its own length and pointer. This shows the written-back length comes from the current frame and the pointer from the current descriptor. The ring is refilled only partly, so the wrapping descriptor is followed by a return to the base. The restart at the parked descriptor is kept apart from a restart at the base. A command strobe is timed onto the exact acknowledge of a not-owned control word, which tells apart a set-wins design from a clear-wins one. The enable is dropped while a fetch is pending, which tells apart completing the access from dropping it, and shows that the index returns to the base.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int DW      = 32;
    localparam int LEN_W   = 16;
    localparam int E_BIT   = 15;
    localparam int W_BIT   = 13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTL,
        ST_PTR,
        ST_HAND,
        ST_WB
    } rxr_state_e;

    typedef struct packed {
        rxr_state_e         st;
        logic [LEN_W-1:0]   ctl;
        logic [DW-1:0]      ptr;
        logic [LEN_W-1:0]   len;
        logic               evt;
    } rxr_fsm_s;
endpackage

// File: rtl/rxr_active.sv
module rxr_active (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic active_o
);
    logic active_d, active_q;

    always_comb begin
        active_d = active_q;
        if (clr_i) active_d = 1'b0;
        if (set_i) active_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active_d;
    end

    assign active_o = active_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> active_o); // R8
    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !set_i |=> !active_o); // R4
endmodule

// File: rtl/rxr_index.sv
module rxr_index #(
    parameter int          AW        = 32,
    parameter logic [31:0] RING_BASE = 32'h0000_1000,
    parameter int          STRIDE    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic          wrap_i,
    input  logic          home_i,
    output logic [AW-1:0] idx_o
);
    localparam logic [AW-1:0] BASE_A = RING_BASE[AW-1:0];
    localparam logic [AW-1:0] STEP_A = AW'(STRIDE);

    logic [AW-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (home_i)
            idx_d = BASE_A;
        else if (adv_i)
            idx_d = wrap_i ? BASE_A : idx_q + STEP_A;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= BASE_A;
        else        idx_q <= idx_d;
    end

    assign idx_o = idx_q;

    AST_WRAP_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && wrap_i |=> idx_o == BASE_A); // R6
    AST_STEP_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !wrap_i && !home_i |=> idx_o == $past(idx_o) + STEP_A); // R6
endmodule

// File: rtl/rx_ring_poller.sv
module rx_ring_poller
    import rxr_pkg::*;
#(
    parameter int          AW        = 32,
    parameter logic [31:0] RING_BASE = 32'h0000_1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             eth_en,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic             buf_valid,
    output logic [DW-1:0]    buf_ptr,
    input  logic             frame_done,
    input  logic [LEN_W-1:0] frame_len,
    output logic             rx_evt,
    output logic             active
);
    localparam int              DESC_BYTES = 8;
    localparam logic [AW-1:0]   PTR_OFS    = AW'(DESC_BYTES / 2);

    rxr_fsm_s      fsm_d, fsm_q;
    logic          clr_act, adv_idx, wrap_idx, home_idx;
    logic [AW-1:0] idx;

    rxr_active u_active (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (cmd_wr),
        .clr_i    (clr_act),
        .active_o (active)
    );

    rxr_index #(
        .AW        (AW),
        .RING_BASE (RING_BASE),
        .STRIDE    (DESC_BYTES)
    ) u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (adv_idx),
        .wrap_i (wrap_idx),
        .home_i (home_idx),
        .idx_o  (idx)
    );

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.evt = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = idx;
        mem_wdata = {fsm_q.len, fsm_q.ctl & ~(LEN_W'(1) << E_BIT)};
        buf_valid = 1'b0;
        clr_act   = 1'b0;
        adv_idx   = 1'b0;
        wrap_idx  = 1'b0;
        home_idx  = !eth_en && (fsm_q.st == ST_IDLE);
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (active && eth_en) fsm_d.st = ST_CTL;
            end
            ST_CTL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fsm_d.ctl = mem_rdata[LEN_W-1:0];
                    if (!eth_en) begin
                        fsm_d.st = ST_IDLE;
                    end else if (!mem_rdata[E_BIT]) begin
                        clr_act  = 1'b1;
                        fsm_d.st = ST_IDLE;
                    end else begin
                        fsm_d.st = ST_PTR;
                    end
                end
            end
            ST_PTR: begin
                mem_req  = 1'b1;
                mem_addr = idx + PTR_OFS;
                if (mem_ack) begin
                    fsm_d.ptr = mem_rdata;
                    fsm_d.st  = eth_en ? ST_HAND : ST_IDLE;
                end
            end
            ST_HAND: begin
                buf_valid = eth_en;
                if (!eth_en) begin
                    fsm_d.st = ST_IDLE;
                end else if (frame_done) begin
                    fsm_d.len = frame_len;
                    fsm_d.st  = ST_WB;
                end
            end
            ST_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    fsm_d.evt = 1'b1;
                    adv_idx   = 1'b1;
                    wrap_idx  = fsm_q.ctl[W_BIT];
                    fsm_d.st  = ST_IDLE;
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, ctl: '0, ptr: '0, len: '0, evt: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign buf_ptr = fsm_q.ptr;
    assign rx_evt  = fsm_q.evt;

    AST_FETCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(active && eth_en)); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9
    AST_WB_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[E_BIT]); // R5
    AST_EVT_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |-> $past(mem_req && mem_we && mem_ack)); // R5
    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid && !frame_done && eth_en |=> $stable(buf_ptr)); // R3
endmodule

// File: tb/rx_ring_poller_tb_top.sv
module rx_ring_poller_tb_top;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic        eth_en = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        buf_valid;
    logic [31:0] buf_ptr;
    logic        frame_done = 1'b0;
    logic [15:0] frame_len = '0;
    logic        rx_evt, active;

    always #2 clk = ~clk;

    rx_ring_poller #(.AW(32), .RING_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .eth_en(eth_en),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .buf_valid(buf_valid), .buf_ptr(buf_ptr), .frame_done(frame_done),
        .frame_len(frame_len), .rx_evt(rx_evt), .active(active)
    );

    // descriptor memory model: 16 words, ack one cycle after request
    logic [31:0] mem [16];
    logic        hw_en = 1'b0;
    logic [3:0]  hw_idx = '0;
    logic [31:0] hw_data = '0;
    assign mem_rdata = mem[mem_addr[5:2]];

    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack && mem_we) mem[mem_addr[5:2]] <= mem_wdata;
        end
        if (hw_en) mem[hw_idx] <= hw_data;
    end

    // access monitor
    int          n_acc = 0;
    logic [31:0] lr_a = '0, lw_a = '0;
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            n_acc++;
            if (mem_we) lw_a = mem_addr;
            else        lr_a = mem_addr;
        end
    end

    int total = 0, bad = 0, cyc = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input int i, input logic [31:0] d);
        @(negedge clk); hw_en = 1'b1; hw_idx = 4'(i); hw_data = d;
        @(negedge clk); hw_en = 1'b0;
    endtask

    task automatic pulse_cmd();
        @(negedge clk); cmd_wr = 1'b1;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic wait_valid(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (buf_valid) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_evt(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (rx_evt) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_idle(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (!active && !mem_req) begin ok = 1'b1; break; end
        end
    endtask

    // run one frame through the offered buffer and check write-back
    task automatic run_frame(input logic [31:0] exp_ptr, input logic [15:0] len,
                             input logic [31:0] exp_addr, input logic [15:0] low_bits);
        bit ok;
        int a0;
        wait_valid(ok);
        check(ok && buf_ptr == exp_ptr, "R3 offered pointer", buf_ptr, exp_ptr);
        repeat (3) @(negedge clk);
        check(buf_valid == 1'b1, "R3 offer held", {31'd0, buf_valid}, 32'd1);
        a0 = n_acc;
        frame_done = 1'b1; frame_len = len;
        @(negedge clk);
        frame_done = 1'b0;
        wait_evt(ok);
        check(ok && n_acc == a0 + 1, "R5 single write", n_acc - a0, 32'd1);
        check(lw_a == exp_addr, "R6 write address", lw_a, exp_addr);
        check(mem[exp_addr[5:2]] == {len, low_bits}, "R5 written control word",
              mem[exp_addr[5:2]], {len, low_bits});
        @(negedge clk);
        check(rx_evt == 1'b0, "R5 event one cycle", {31'd0, rx_evt}, 32'd0);
    endtask

    // stimulus table: {frame length, expected buffer pointer}
    localparam logic [47:0] VEC [3] = '{
        {16'd64,   32'h0000_A000},
        {16'd1518, 32'h0000_A100},
        {16'd301,  32'h0000_A200}
    };

    initial begin
        bit ok;
        int a0;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(active == 1'b0, "R7 reset active", {31'd0, active}, 32'd0);
        check(mem_req == 1'b0 && buf_valid == 1'b0, "R7 reset outputs",
              {30'd0, mem_req, buf_valid}, 32'd0);

        for (int i = 0; i < 3; i++) begin
            host_wr(2*i,   32'h0000_8000);
            host_wr(2*i+1, 32'h0000_A000 + 32'(i) * 32'h100);
        end
        host_wr(6, 32'h0000_2000);   // wrap set, not owned
        host_wr(7, 32'h0000_A300);

        // enabled but not armed: no access (R2)
        eth_en = 1'b1;
        a0 = n_acc;
        repeat (10) @(negedge clk);
        check(n_acc == a0, "R2 no access while disarmed", n_acc - a0, 32'd0);

        // armed but disabled: no access (R2), arm from any write (R1)
        eth_en = 1'b0;
        pulse_cmd();
        check(active == 1'b1, "R1 armed by write", {31'd0, active}, 32'd1);
        repeat (10) @(negedge clk);
        check(n_acc == a0, "R2 no access while disabled", n_acc - a0, 32'd0);
        eth_en = 1'b1;

        for (int i = 0; i < 3; i++) begin
            run_frame(VEC[i][31:0], VEC[i][47:32], BASE + 32'(8*i), 16'h0000);
            if (i == 0) check(lr_a == BASE + 32'd4 || lr_a == BASE, "R7 first fetch at base", lr_a, BASE);
        end

        // not-owned descriptor 3 parks the poller (R4)
        wait_idle(ok);
        check(ok && lr_a == BASE + 32'd24, "R4 disarm on not-owned", lr_a, BASE + 32'd24);
        a0 = n_acc;
        repeat (10) @(negedge clk);
        check(n_acc == a0, "R4 no polling after disarm", n_acc - a0, 32'd0);

        // refill descriptor 3 and 0; restart at parked descriptor, then wrap (R4, R6)
        host_wr(6, 32'h0000_A000);
        host_wr(0, 32'h0000_8000);
        host_wr(1, 32'h0000_B000);
        pulse_cmd();
        run_frame(32'h0000_A300, 16'd90, BASE + 32'd24, 16'h2000);
        run_frame(32'h0000_B000, 16'd77, BASE, 16'h0000);
        wait_idle(ok);
        check(ok && lr_a == BASE + 32'd8, "R6 continue after wrap", lr_a, BASE + 32'd8);

        // command write in the same cycle as the self-clear (R8)
        @(negedge clk); cmd_wr = 1'b1;
        @(negedge clk); cmd_wr = 1'b0;
        ok = 1'b0;
        for (int k = 0; k < 50; k++) begin
            if (mem_req && mem_ack && !mem_we) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        check(ok && active == 1'b1, "R8 write wins over clear", {31'd0, active}, 32'd1);
        wait_idle(ok);
        check(ok, "R4 disarm after re-poll", {31'd0, active}, 32'd0);

        // drop enable while a fetch is pending (R9)
        host_wr(2, 32'h0000_8000);
        host_wr(4, 32'h0000_8000);
        pulse_cmd();
        ok = 1'b0;
        for (int k = 0; k < 50; k++) begin
            if (mem_req && !mem_ack && !mem_we) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        a0 = n_acc;
        eth_en = 1'b0;
        @(negedge clk);
        check(ok && mem_req == 1'b1, "R9 pending access held", {31'd0, mem_req}, 32'd1);
        repeat (12) @(negedge clk);
        check(n_acc == a0 + 1, "R9 no new access", n_acc - a0, 32'd1);
        check(buf_valid == 1'b0, "R9 no offer while disabled", {31'd0, buf_valid}, 32'd0);
        eth_en = 1'b1;
        ok = 1'b0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (n_acc != a0 + 1) begin ok = 1'b1; break; end
        end
        check(ok && lr_a == BASE, "R9 restart at base", lr_a, BASE);
        wait_idle(ok);
        check(ok, "R4 base descriptor not owned", {31'd0, active}, 32'd0);

        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule